// File: doc/BRIEF.md
# Multi-mode link test pattern mapper

This block produces the data words for three 24-bit serial links. In normal operation it spreads two 36-bit input buses, A and B, across the three links. Two of the modes copy the low 24 bits of the buses onto the lanes. A packing mode carries all 72 input bits, splitting them at 12-bit boundaries. The other modes replace the bus data with a built-in pattern, so that each link and its receiver can be checked without upstream traffic. The patterns are fixed constants, two linear feedback shift registers, a counter, a walking one, a toggling word, and a shifter that feeds back its inverted top bit.

An 8-bit mode input selects the source. A separate force input overrides every mode and sends one fixed word. All three lane outputs are registered, so each output follows the inputs present at the previous rising clock edge. All pattern generators run freely from reset, whichever mode is selected.

Top module: `lpm_top`

## Requirements
- R1: While reset is asserted, and right after it, all three lane outputs are 0x000000.
- R2: Mode 0x00 drives lane0 and lane2 with A[23:0] and lane1 with B[23:0]. Mode 0x01 drives lane0 and lane2 with B[23:0] and lane1 with A[23:0].
- R3: Mode 0xF0 drives lane0 = A[23:0], lane1 = {B[11:0], A[35:24]} and lane2 = B[35:12].
- R4: Each constant mode drives the same word on all three lanes. The words are 0x111111 for 0xF1, 0x222222 for 0xF2, 0x555555 for 0xFB, 0xAAAAAA for 0xFC, 0xA5A5A5 for 0xFD, 0xFFFFFF for 0xFE and 0x000000 for 0xFF.
- R5: Mode 0xF3 drives a 24-bit LFSR, identical on all lanes, that is never zero. Each clock it steps from s to {s[22:0], s[23]^s[22]^s[21]^s[16]}.
- R6: Mode 0xF6 drives a 24-bit counter on all lanes. It rises by one each clock and wraps modulo 2^24.
- R7: Mode 0xF5 drives 0x555555 and 0xAAAAAA on all lanes, changing from one to the other on every clock.
- R8: Mode 0xF4 drives a word with exactly one bit set on all lanes. The word rotates left by one bit each clock, with bit 23 wrapping to bit 0.
- R9: Mode 0xF7 drives a shifter on all lanes that steps from s to {s[22:0], ~s[23]} each clock.
- R10: Mode 0xF8 works from a 32-bit LFSR L that steps from L to {L[30:0], L[31]^L[21]^L[1]^L[0]} each clock. The lanes are lane0 = L[23:0], lane1 = {L[11:0], 4'h5, L[31:24]} and lane2 = {4'hA, L[31:12]}.
- R11: Mode 0xF9 drives an 8-bit walking one that rotates left each clock. Mode 0xFA drives an 8-bit counter that rises by one each clock. In both modes the 8-bit value fills all three bytes of every lane.
- R12: Every mode not listed above (0x02 to 0xEF) drives 0x000000 on all lanes.
- R13: While force is high, all lanes carry 0x123456, whatever the mode.
- R14: The outputs are registered. A change on the mode, force or bus inputs appears on the lanes after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 8 | Selects the lane source |
| forceConst | input | 1 | Drives the fixed force word on all lanes |
| busA | input | 36 | Input data bus A |
| busB | input | 36 | Input data bus B |
| lane0 | output | 24 | Link 0 data word |
| lane1 | output | 24 | Link 1 data word |
| lane2 | output | 24 | Link 2 data word |

## Verification
The mapping modes are driven with bus words in which every 12-bit slice is different, so that a swapped lane, a misplaced slice, or A confused with B gives a visibly wrong word. A second pair of bus values, applied without changing the mode, shows that the lanes follow the data one clock later. The pattern modes are sampled over several consecutive cycles. Each sample is checked against the step rule applied to the previous sample, which catches wrong taps, a wrong shift direction, a missing inversion or a broken field layout without relying on seeds. Unused modes and force are tried with live bus data and running generators, so that any leak of those sources shows up.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int LANE_W = 24;
  localparam int BUS_W  = 36;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_MAP0, SEL_MAP1, SEL_PACK, SEL_CONST,
    SEL_LFSR24, SEL_CNT24, SEL_ROT24, SEL_TOG, SEL_SHIFT,
    SEL_MIX32, SEL_ROT8, SEL_CNT8
  } laneSelE;

  typedef struct packed {
    laneSelE             sel;
    logic [LANE_W-1:0]   constWord;
  } laneCtrlT;
endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter logic [LANE_W-1:0] FORCE_WORD = 24'h123456
) (
  input  logic [7:0] mode,
  input  logic       forceConst,
  output laneCtrlT   ctrl
);
  always_comb begin
    ctrl.sel       = SEL_ZERO;
    ctrl.constWord = '0;
    if (forceConst) begin
      ctrl.sel       = SEL_CONST;
      ctrl.constWord = FORCE_WORD;
    end else begin
      case (mode)
        8'h00: ctrl.sel = SEL_MAP0;
        8'h01: ctrl.sel = SEL_MAP1;
        8'hF0: ctrl.sel = SEL_PACK;
        8'hF1: begin ctrl.sel = SEL_CONST; ctrl.constWord = 24'h111111; end
        8'hF2: begin ctrl.sel = SEL_CONST; ctrl.constWord = 24'h222222; end
        8'hF3: ctrl.sel = SEL_LFSR24;
        8'hF4: ctrl.sel = SEL_ROT24;
        8'hF5: ctrl.sel = SEL_TOG;
        8'hF6: ctrl.sel = SEL_CNT24;
        8'hF7: ctrl.sel = SEL_SHIFT;
        8'hF8: ctrl.sel = SEL_MIX32;
        8'hF9: ctrl.sel = SEL_ROT8;
        8'hFA: ctrl.sel = SEL_CNT8;
        8'hFB: begin ctrl.sel = SEL_CONST; ctrl.constWord = 24'h555555; end
        8'hFC: begin ctrl.sel = SEL_CONST; ctrl.constWord = 24'hAAAAAA; end
        8'hFD: begin ctrl.sel = SEL_CONST; ctrl.constWord = 24'hA5A5A5; end
        8'hFE: begin ctrl.sel = SEL_CONST; ctrl.constWord = 24'hFFFFFF; end
        8'hFF: begin ctrl.sel = SEL_CONST; ctrl.constWord = 24'h000000; end
        default: ctrl.sel = SEL_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter logic [23:0] LFSR24_SEED = 24'h000001,
  parameter logic [31:0] LFSR32_SEED = 32'h00000001,
  parameter int          NUM_LANES   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  laneCtrlT          ctrl,
  input  logic [BUS_W-1:0]  busA,
  input  logic [BUS_W-1:0]  busB,
  output logic [LANE_W-1:0] laneOut [NUM_LANES]
);
  localparam int HALF_W = LANE_W / 2;
  localparam int BYTES  = LANE_W / 8;

  logic [23:0] lfsr24State;
  logic [31:0] lfsr32State;
  logic [23:0] cnt24State;
  logic [23:0] rot24State;
  logic [23:0] togState;
  logic [23:0] shiftState;
  logic [7:0]  rot8State;
  logic        pastValid;

  logic        fb24;
  logic        fb32;
  assign fb24 = lfsr24State[23] ^ lfsr24State[22] ^ lfsr24State[21] ^ lfsr24State[16];
  assign fb32 = lfsr32State[31] ^ lfsr32State[21] ^ lfsr32State[1] ^ lfsr32State[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr24State <= LFSR24_SEED;
      lfsr32State <= LFSR32_SEED;
      cnt24State  <= '0;
      rot24State  <= 24'h000001;
      togState    <= 24'h555555;
      shiftState  <= '0;
      rot8State   <= 8'h01;
      pastValid   <= 1'b0;
    end else begin
      lfsr24State <= {lfsr24State[22:0], fb24};
      lfsr32State <= {lfsr32State[30:0], fb32};
      cnt24State  <= cnt24State + 24'd1;
      rot24State  <= {rot24State[22:0], rot24State[23]};
      togState    <= ~togState;
      shiftState  <= {shiftState[22:0], ~shiftState[23]};
      rot8State   <= {rot8State[6:0], rot8State[7]};
      pastValid   <= 1'b1;
    end
  end

  logic [LANE_W-1:0] laneD [NUM_LANES];

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) laneD[i] = '0;
    case (ctrl.sel)
      SEL_MAP0: begin
        laneD[0] = busA[LANE_W-1:0];
        laneD[1] = busB[LANE_W-1:0];
        laneD[2] = busA[LANE_W-1:0];
      end
      SEL_MAP1: begin
        laneD[0] = busB[LANE_W-1:0];
        laneD[1] = busA[LANE_W-1:0];
        laneD[2] = busB[LANE_W-1:0];
      end
      SEL_PACK: begin
        laneD[0] = busA[LANE_W-1:0];
        laneD[1] = {busB[HALF_W-1:0], busA[BUS_W-1:LANE_W]};
        laneD[2] = busB[BUS_W-1:HALF_W];
      end
      SEL_MIX32: begin
        laneD[0] = lfsr32State[23:0];
        laneD[1] = {lfsr32State[11:0], 4'h5, lfsr32State[31:24]};
        laneD[2] = {4'hA, lfsr32State[31:12]};
      end
      default: begin
        for (int i = 0; i < NUM_LANES; i++) begin
          case (ctrl.sel)
            SEL_CONST:  laneD[i] = ctrl.constWord;
            SEL_LFSR24: laneD[i] = lfsr24State;
            SEL_CNT24:  laneD[i] = cnt24State;
            SEL_ROT24:  laneD[i] = rot24State;
            SEL_TOG:    laneD[i] = togState;
            SEL_SHIFT:  laneD[i] = shiftState;
            SEL_ROT8:   laneD[i] = {BYTES{rot8State}};
            SEL_CNT8:   laneD[i] = {BYTES{cnt24State[7:0]}};
            default:    laneD[i] = '0;
          endcase
        end
      end
    endcase
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (rst) laneOut[g] <= '0;
      else     laneOut[g] <= laneD[g];
    end
  end

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr24State != '0);
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    pastValid |-> cnt24State == 24'($past(cnt24State) + 24'd1));
  // R8
  rot_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(rot24State) == 1);
  // R11
  rot8_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(rot8State) == 1);
  // R13
  const_out_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.sel == SEL_CONST |=> laneOut[0] == $past(ctrl.constWord)
                              && laneOut[1] == laneOut[0] && laneOut[2] == laneOut[0]);
  // R2
  map0_out_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.sel == SEL_MAP0 |=> laneOut[1] == $past(busB[LANE_W-1:0]));
  // R12
  zero_out_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.sel == SEL_ZERO |=> laneOut[0] == '0 && laneOut[1] == '0 && laneOut[2] == '0);
endmodule

// File: rtl/lpm_top.sv
module lpm_top
  import lpm_pkg::*;
#(
  parameter logic [23:0] FORCE_WORD  = 24'h123456,
  parameter logic [23:0] LFSR24_SEED = 24'h000001,
  parameter logic [31:0] LFSR32_SEED = 32'h00000001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  mode,
  input  logic        forceConst,
  input  logic [35:0] busA,
  input  logic [35:0] busB,
  output logic [23:0] lane0,
  output logic [23:0] lane1,
  output logic [23:0] lane2
);
  laneCtrlT    ctrl;
  logic [23:0] laneOut [3];

  lpm_ctrl #(.FORCE_WORD(FORCE_WORD)) uCtrl (
    .mode(mode), .forceConst(forceConst), .ctrl(ctrl)
  );

  lpm_datapath #(
    .LFSR24_SEED(LFSR24_SEED), .LFSR32_SEED(LFSR32_SEED), .NUM_LANES(3)
  ) uDp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .busA(busA), .busB(busB), .laneOut(laneOut)
  );

  assign lane0 = laneOut[0];
  assign lane1 = laneOut[1];
  assign lane2 = laneOut[2];
endmodule

// File: tb/tb_lpm_top.sv
`timescale 1ns/1ps
module tb_lpm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mode = 8'h00;
  logic        forceConst = 1'b0;
  logic [35:0] busA = '0;
  logic [35:0] busB = '0;
  logic [23:0] lane0, lane1, lane2;
  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  lpm_top dut (
    .clk(clk), .rst(rst), .mode(mode), .forceConst(forceConst),
    .busA(busA), .busB(busB), .lane0(lane0), .lane1(lane1), .lane2(lane2)
  );

  task automatic check(string req, logic [71:0] act, logic [71:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] lanesNow();
    return {lane2, lane1, lane0};
  endfunction

  function automatic logic [71:0] all3(logic [23:0] w);
    return {w, w, w};
  endfunction

  task automatic setMode(logic [7:0] m);
    @(negedge clk);
    mode = m;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 during reset", lanesNow(), '0);
    busA = 36'hFEDCBA987; busB = 36'h123456789;
    @(negedge clk); rst = 1'b0;
    mode = 8'h05;
    @(negedge clk);
    check("R1 after reset", lanesNow(), '0);
  endtask

  task automatic testMap();
    busA = 36'hABC123456; busB = 36'hDEF789ABC;
    setMode(8'h00);
    check("R2 mode0", lanesNow(), {24'h123456, 24'h789ABC, 24'h123456});
    busA = 36'h111654321; busB = 36'h222CBA987;
    @(negedge clk);
    check("R14 mode0 data follows one clock later", lanesNow(),
          {24'h654321, 24'hCBA987, 24'h654321});
    setMode(8'h01);
    check("R2 mode1", lanesNow(), {24'hCBA987, 24'h654321, 24'hCBA987});
  endtask

  task automatic testPack();
    busA = 36'h321CBA987; busB = 36'h6549F0E1D;
    setMode(8'hF0);
    check("R3 pack", lanesNow(), {24'h6549F0, 24'hE1D321, 24'hCBA987});
  endtask

  task automatic testConst();
    logic [7:0]  m [7] = '{8'hF1, 8'hF2, 8'hFB, 8'hFC, 8'hFD, 8'hFE, 8'hFF};
    logic [23:0] w [7] = '{24'h111111, 24'h222222, 24'h555555, 24'hAAAAAA,
                           24'hA5A5A5, 24'hFFFFFF, 24'h000000};
    for (int i = 0; i < 7; i++) begin
      setMode(m[i]);
      check($sformatf("R4 const mode %h", m[i]), lanesNow(), all3(w[i]));
    end
  endtask

  task automatic testLfsr24();
    logic [23:0] p;
    setMode(8'hF3);
    p = lane0;
    check("R5 lfsr24 lanes equal", lanesNow(), all3(p));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R5 lfsr24 step", lanesNow(),
            all3({p[22:0], p[23] ^ p[22] ^ p[21] ^ p[16]}));
      check("R5 lfsr24 nonzero", {71'd0, lane0 == 24'd0}, 72'd0);
      p = lane0;
    end
  endtask

  task automatic testCounter();
    logic [23:0] p;
    setMode(8'hF6);
    p = lane0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R6 counter step", lanesNow(), all3(p + 24'd1));
      p = lane0;
    end
  endtask

  task automatic testToggle();
    logic [23:0] p;
    setMode(8'hF5);
    p = lane0;
    check("R7 toggle legal word", {71'd0, (p == 24'h555555 || p == 24'hAAAAAA)}, 72'd1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 toggle alternate", lanesNow(), all3(~p));
      p = lane0;
    end
  endtask

  task automatic testRot24();
    logic [23:0] p;
    setMode(8'hF4);
    p = lane0;
    check("R8 rotate one-hot", {64'd0, 8'($countones(p))}, 72'd1);
    for (int i = 0; i < 26; i++) begin
      @(negedge clk);
      if (i % 8 == 0 || i == 25)
        check("R8 rotate step", lanesNow(), all3({p[22:0], p[23]}));
      p = lane0;
    end
  endtask

  task automatic testShift();
    logic [23:0] p;
    setMode(8'hF7);
    p = lane0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i % 6 == 0 || i == 29)
        check("R9 inverted feedback shift", lanesNow(), all3({p[22:0], ~p[23]}));
      p = lane0;
    end
  endtask

  task automatic testMix32();
    logic [31:0] l, n;
    setMode(8'hF8);
    l = {lane1[7:0], lane0};
    check("R10 mix layout", lanesNow(),
          {4'hA, l[31:12], l[11:0], 4'h5, l[31:24], l[23:0]});
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      n = {l[30:0], l[31] ^ l[21] ^ l[1] ^ l[0]};
      check("R10 lfsr32 step and layout", lanesNow(),
            {4'hA, n[31:12], n[11:0], 4'h5, n[31:24], n[23:0]});
      l = {lane1[7:0], lane0};
    end
  endtask

  task automatic testByteModes();
    logic [7:0] p;
    setMode(8'hF9);
    p = lane0[7:0];
    check("R11 rot8 one-hot", {64'd0, 8'($countones(p))}, 72'd1);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (i % 3 == 0)
        check("R11 rot8 step and replicate", lanesNow(), {9{p[6:0], p[7]}});
      p = lane0[7:0];
    end
    setMode(8'hFA);
    p = lane0[7:0];
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 cnt8 step and replicate", lanesNow(), {9{8'(p + 8'd1)}});
      p = lane0[7:0];
    end
  endtask

  task automatic testUnused();
    logic [7:0] m [4] = '{8'h02, 8'h7F, 8'hEF, 8'h80};
    busA = 36'hFFFFFFFFF; busB = 36'hFFFFFFFFF;
    for (int i = 0; i < 4; i++) begin
      setMode(m[i]);
      check($sformatf("R12 unused mode %h", m[i]), lanesNow(), '0);
    end
  endtask

  task automatic testForce();
    busA = 36'h0ABCDEF01; busB = 36'h0FEDCBA98;
    setMode(8'h00);
    @(negedge clk); forceConst = 1'b1;
    @(negedge clk);
    check("R13 force over mode0", lanesNow(), all3(24'h123456));
    mode = 8'hF3;
    @(negedge clk);
    check("R13 force over lfsr", lanesNow(), all3(24'h123456));
    mode = 8'hFF;
    @(negedge clk);
    check("R13 force over zero const", lanesNow(), all3(24'h123456));
    forceConst = 1'b0;
    @(negedge clk);
    check("R14 release force", lanesNow(), '0);
  endtask

  initial begin
    testReset();
    testMap();
    testPack();
    testConst();
    testLfsr24();
    testCounter();
    testToggle();
    testRot24();
    testShift();
    testMix32();
    testByteModes();
    testUnused();
    testForce();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #100000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule